// File: doc/BRIEF.md
# Per-Channel Fault Code Register with Qualified Latching

This block gathers fault indications from eight low-side output channels and packs them into a 16-bit diagnostic word. Each channel gets a two-bit code. The word is read out by a serial access. Each channel has three raw inputs: over-current (which also covers a short to supply or over-temperature), short to ground, and open load. These come from the analog sensing stages. A raw condition is only accepted after it has stayed present for a programmable number of system-clock cycles. That filter hides the short glitches that appear while an output settles.

Once accepted, a code is held until the serial block signals that an access has ended. A later accepted fault on the same channel replaces the stored code. An active-low flag, common to all channels, shows whether any channel holds a fault code. The host uses it as an interrupt, so it only needs to read the word when something has gone wrong.

Top module: `diag_word_collector`

## Requirements
- R1: While `rst` is high on a clock edge, every channel code becomes 2'b11 after that edge and `fault_n` is 1.
- R2: The code for one channel depends on which raw inputs are active, by priority. Over-current gives 2'b10, and it wins over everything. Short to ground gives 2'b00. Open load alone gives 2'b01. No active input means normal, 2'b11.
- R3: Channel k (k = 0..7) sits in `diag_word[2k+1:2k]`. The highest channel therefore uses bits 15:14.
- R4: A candidate fault code is latched on the QUAL_TICKS-th consecutive rising edge at which the same candidate is present. A candidate held for fewer edges leaves the stored code unchanged.
- R5: The qualification count starts again from one when the candidate returns to normal and then reappears. It also starts again when the candidate changes to a different fault code.
- R6: A stored code stays the same after its raw condition disappears. In any cycle with no raw inputs and no clear, the word does not change.
- R7: A newly qualified fault code on a channel overwrites the code already stored for that channel.
- R8: `fault_n` is 0 exactly when at least one channel holds a code other than 2'b11.
- R9: A one-cycle `clr_strobe` sets every channel code to 2'b11 after the edge that samples it. In that cycle the clear wins over any qualification.
- R10: A clear does not restart qualification. A fault that is still present and already qualified is latched again one edge after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ovl_raw | input | 8 | Per-channel over-current / short to supply / over-temperature indication |
| shg_raw | input | 8 | Per-channel short-to-ground indication |
| open_raw | input | 8 | Per-channel open-load indication |
| clr_strobe | input | 1 | One-cycle pulse from the serial block at the end of an access |
| diag_word | output | 16 | Two-bit code per channel, channel k in bits 2k+1:2k |
| fault_n | output | 1 | Active-low common fault flag |

## Verification
The bench holds a fault for one edge less than the qualification length and then for exactly that length. A design whose count is off by one would latch too early or miss the latch. It also breaks a held fault with a single-cycle gap, and switches a held fault to a different code part-way through. A filter that failed to restart would then report faults that never lasted long enough. Two more directed cases cover priority and clearing. All three inputs are raised at once and checked against the encoded value in the top bit pair, which exposes a swapped priority or a misplaced field. A clear is pulsed while a fault persists, which shows whether the clear is lost, or whether it wrongly forces a full new qualification. Long runs of random stimulus with random holds and clears are then compared every cycle against a run-length model.

// File: rtl/diag_pkg.sv
package diag_pkg;

    typedef enum logic [1:0] {
        CODE_SHG  = 2'b00,
        CODE_OPEN = 2'b01,
        CODE_OVL  = 2'b10,
        CODE_OK   = 2'b11
    } diag_code_t;

    // Priority: over-current first, then short to ground, then open load
    function automatic diag_code_t select_code(input logic ovl, input logic shg,
                                               input logic opn);
        diag_code_t c;
        if (ovl)      c = CODE_OVL;
        else if (shg) c = CODE_SHG;
        else if (opn) c = CODE_OPEN;
        else          c = CODE_OK;
        return c;
    endfunction

endpackage

// File: rtl/diag_qualify.sv
module diag_qualify
    import diag_pkg::*;
#(
    parameter int QUAL_TICKS = 20000
) (
    input  logic       clk,
    input  logic       rst,
    input  diag_code_t cand,
    output logic       hit
);
    localparam int CW = $clog2(QUAL_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_TICKS - 1);
    localparam logic [CW-1:0] TOP  = CW'(QUAL_TICKS);

    diag_code_t    prev_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= CODE_OK;
            run_q  <= '0;
        end else begin
            prev_q <= cand;
            if (cand == CODE_OK)
                run_q <= '0;
            else if (cand != prev_q)
                run_q <= CW'(1);
            else if (run_q < TOP)
                run_q <= run_q + CW'(1);
        end
    end

    always_comb begin
        hit = (cand != CODE_OK) && (cand == prev_q) && (run_q >= LAST);
    end

endmodule

// File: rtl/diag_slot.sv
module diag_slot
    import diag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       hit,
    input  diag_code_t cand,
    output diag_code_t code
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            code <= CODE_OK;
        else if (hit)
            code <= cand;
    end
endmodule

// File: rtl/diag_flag.sv
module diag_flag #(
    parameter int NUM_CH = 8
) (
    input  logic [2*NUM_CH-1:0] word,
    output logic                fault_n
);
    logic [NUM_CH-1:0] bad;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_bad
        assign bad[k] = (word[2*k +: 2] != 2'b11);
    end

    assign fault_n = ~(|bad);
endmodule

// File: rtl/diag_word_collector.sv
module diag_word_collector
    import diag_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int QUAL_TICKS = 20000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CH-1:0]   ovl_raw,
    input  logic [NUM_CH-1:0]   shg_raw,
    input  logic [NUM_CH-1:0]   open_raw,
    input  logic                clr_strobe,
    output logic [2*NUM_CH-1:0] diag_word,
    output logic                fault_n
);
    initial begin
        if (QUAL_TICKS < 2) $error("QUAL_TICKS must be at least 2");
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        diag_code_t cand;
        diag_code_t code;
        logic       hit;

        assign cand = select_code(ovl_raw[k], shg_raw[k], open_raw[k]);

        diag_qualify #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
            .clk  (clk),
            .rst  (rst),
            .cand (cand),
            .hit  (hit)
        );

        diag_slot u_slot (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr_strobe),
            .hit  (hit),
            .cand (cand),
            .code (code)
        );

        assign diag_word[2*k +: 2] = code;
    end

    diag_flag #(.NUM_CH(NUM_CH)) u_flag (
        .word    (diag_word),
        .fault_n (fault_n)
    );
endmodule

// File: rtl/diag_word_checks.sv
module diag_word_checks #(
    parameter int NUM_CH = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_CH-1:0]   ovl_raw,
    input logic [NUM_CH-1:0]   shg_raw,
    input logic [NUM_CH-1:0]   open_raw,
    input logic                clr_strobe,
    input logic [2*NUM_CH-1:0] diag_word,
    input logic                fault_n
);
    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (diag_word == '1) && fault_n); // R1

    AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (rst)
        clr_strobe |=> (diag_word == '1)); // R9

    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        fault_n == (diag_word == '1)); // R8

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr_strobe && ovl_raw == '0 && shg_raw == '0 && open_raw == '0)
        |=> $stable(diag_word)); // R6
endmodule

bind diag_word_collector diag_word_checks #(.NUM_CH(NUM_CH)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .ovl_raw    (ovl_raw),
    .shg_raw    (shg_raw),
    .open_raw   (open_raw),
    .clr_strobe (clr_strobe),
    .diag_word  (diag_word),
    .fault_n    (fault_n)
);

// File: tb/sim_diag_word_collector.sv
`timescale 1ns/1ps
module sim_diag_word_collector;
    localparam int NCH = 8;
    localparam int Q   = 12;

    logic           clk = 1'b0;
    logic           rst;
    logic [NCH-1:0] ovl_raw, shg_raw, open_raw;
    logic           clr_strobe;
    logic [2*NCH-1:0] diag_word;
    logic           fault_n;

    always #2.5 clk = ~clk;

    diag_word_collector #(.NUM_CH(NCH), .QUAL_TICKS(Q)) u0 (
        .clk(clk), .rst(rst), .ovl_raw(ovl_raw), .shg_raw(shg_raw),
        .open_raw(open_raw), .clr_strobe(clr_strobe),
        .diag_word(diag_word), .fault_n(fault_n)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [1:0] m_prev [NCH];
    int         m_run  [NCH];
    logic [1:0] m_exp  [NCH];
    int         hold   [NCH];

    function automatic logic [1:0] pick(input logic o, input logic s, input logic p);
        if (o) return 2'b10;
        if (s) return 2'b00;
        if (p) return 2'b01;
        return 2'b11;
    endfunction

    function automatic logic [15:0] exp_word();
        logic [15:0] w;
        for (int k = 0; k < NCH; k++) w[2*k +: 2] = m_exp[k];
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        for (int k = 0; k < NCH; k++) begin
            logic [1:0] s;
            if (rst) begin
                m_run[k] = 0; m_prev[k] = 2'b11; m_exp[k] = 2'b11;
            end else begin
                s = pick(ovl_raw[k], shg_raw[k], open_raw[k]);
                if (s == 2'b11)          m_run[k] = 0;
                else if (s != m_prev[k]) m_run[k] = 1;
                else if (m_run[k] < Q)   m_run[k] = m_run[k] + 1;
                m_prev[k] = s;
                if (clr_strobe)          m_exp[k] = 2'b11;
                else if (m_run[k] >= Q)  m_exp[k] = s;
            end
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({tag, " word"}, 32'(diag_word), 32'(exp_word()));
        chk({tag, " flag"}, 32'(fault_n), 32'(exp_word() == 16'hFFFF));
    endtask

    task automatic set_raw(input int ch, input logic o, input logic s, input logic p);
        ovl_raw[ch] = o; shg_raw[ch] = s; open_raw[ch] = p;
    endtask

    function automatic logic [1:0] fld(input int ch);
        return diag_word[2*ch +: 2];
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; clr_strobe = 0; ovl_raw = '0; shg_raw = '0; open_raw = '0;
        for (int k = 0; k < NCH; k++) begin
            m_run[k] = 0; m_prev[k] = 2'b11; m_exp[k] = 2'b11; hold[k] = 0;
        end
        repeat (3) tick("R1 reset");
        chk("R1 reset word", 32'(diag_word), 32'hFFFF);
        chk("R1 reset flag", 32'(fault_n), 32'd1);
        rst = 0;
        tick("R1 idle");

        // R4: one edge short of qualification
        set_raw(2, 1, 0, 0);
        repeat (Q - 1) tick("R4 short");
        chk("R4 not latched", 32'(fld(2)), 32'h3);
        set_raw(2, 0, 0, 0);
        tick("R4 gap");
        // R4 / R3 / R2: exact qualification length
        set_raw(2, 1, 0, 0);
        repeat (Q) tick("R4 exact");
        chk("R4 R3 ch2 over-current at bits 5:4", 32'(diag_word), 32'hFFEF);
        chk("R8 flag low", 32'(fault_n), 32'd0);
        // R6: held after removal
        set_raw(2, 0, 0, 0);
        repeat (5) tick("R6 hold");
        chk("R6 code kept", 32'(fld(2)), 32'h2);

        // R5: gap restarts count
        set_raw(5, 0, 0, 1);
        repeat (Q - 1) tick("R5 a");
        set_raw(5, 0, 0, 0);
        tick("R5 gap");
        set_raw(5, 0, 0, 1);
        repeat (Q - 1) tick("R5 b");
        chk("R5 restart after gap", 32'(fld(5)), 32'h3);
        // R5: code change restarts count
        set_raw(5, 0, 1, 0);
        repeat (Q - 1) tick("R5 c");
        chk("R5 restart on code change", 32'(fld(5)), 32'h3);
        tick("R5 d");
        chk("R5 latched short to ground", 32'(fld(5)), 32'h0);
        set_raw(5, 0, 0, 0);

        // R7: overwrite on ch2
        set_raw(2, 0, 1, 0);
        repeat (Q) tick("R7 overwrite");
        chk("R7 new code replaces old", 32'(fld(2)), 32'h0);
        set_raw(2, 0, 0, 0);

        // R2 / R3: priority in the top field
        set_raw(7, 1, 1, 1);
        set_raw(6, 0, 1, 1);
        set_raw(0, 0, 0, 1);
        repeat (Q) tick("R2 priority");
        chk("R2 R3 ch7 bits 15:14", 32'(diag_word[15:14]), 32'h2);
        chk("R2 ch6 short beats open", 32'(fld(6)), 32'h0);
        chk("R2 ch0 open load", 32'(fld(0)), 32'h1);
        set_raw(7, 0, 0, 0); set_raw(6, 0, 0, 0); set_raw(0, 0, 0, 0);

        // R9: clear
        tick("R9 pre");
        clr_strobe = 1;
        tick("R9 clear");
        clr_strobe = 0;
        chk("R9 word cleared", 32'(diag_word), 32'hFFFF);
        chk("R9 R8 flag released", 32'(fault_n), 32'd1);

        // R10: clear during a persisting fault
        set_raw(4, 1, 0, 0);
        repeat (Q + 2) tick("R10 build");
        clr_strobe = 1;
        tick("R10 clear");
        clr_strobe = 0;
        chk("R10 cleared", 32'(fld(4)), 32'h3);
        tick("R10 relatch");
        chk("R10 relatched next edge", 32'(fld(4)), 32'h2);
        set_raw(4, 0, 0, 0);

        // random phase, checked each cycle against the model (R2 R4 R5 R7 R9)
        for (int n = 0; n < 4000; n++) begin
            for (int k = 0; k < NCH; k++) begin
                if (hold[k] == 0) begin
                    hold[k] = 1 + int'($urandom_range(2 * Q));
                    if ($urandom_range(1) == 0) set_raw(k, 0, 0, 0);
                    else set_raw(k, 1'($urandom), 1'($urandom), 1'($urandom));
                end else begin
                    hold[k] = hold[k] - 1;
                end
            end
            clr_strobe = ($urandom_range(39) == 0);
            tick("R4 R7 R9 random");
        end
        clr_strobe = 0;

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule